// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the device side of a three-wire serial memory port. It brings the chip-select, serial clock and serial data inputs into the system clock domain and waits for a start bit. It then collects a two-bit opcode, an address and, for the two write forms, a data word. From these it produces requests for a program sequencer and a read port. A single organization input picks either byte words or 16-bit words, which changes both the address and the data length of every instruction.

Reads answer on the serial output. A zero comes first, then the addressed word, most significant bit first. While chip-select stays high, the following words keep streaming with the address stepping up and wrapping. Program operations are erase, write, erase-all and write-all. Each is handed to the sequencer when chip-select falls after a complete instruction, and only if programming has been enabled. If chip-select rises again later, the serial output reports ready or busy. The output-enable pin stands in for the high-impedance state. The storage array and the program timing sit outside this block: the sequencer reports busy through an input.

Top module: `mw_front`

## Requirements
- R1: After reset `do_oe_o`, `rd_en_o` and `prog_req_o` are 0, and programming is disabled.
- R2: With chip-select high, serial clock rising edges taken while data-in is 0 before any start bit change no state. The start bit is the first rising edge with both chip-select and data-in high.
- R3: Opcode 2'b10 (the two bits after the start bit, first one the MSB) is a read. After the last address bit the output is enabled and shows 0. Each following rising edge shows the next bit of `rd_data_i`, MSB first: all 16 bits in word organization (`org_word_i`=1), bits 7..0 in byte organization.
- R4: The address is ADDR_W bits (6) in word organization and ADDR_W+1 bits (7) in byte organization, sent MSB first. Write data is 16 or 8 bits respectively.
- R5: If chip-select stays high after a read word, the address increments, wrapping within the current address width. The next word follows at once with no dummy bit.
- R6: Program requests are issued only while programming is enabled. Opcode 2'b00 with top two address bits 2'b11 enables programming. With 2'b00 in those bits it disables programming. Reset leaves programming disabled.
- R7: A complete write (opcode 2'b01) or erase (opcode 2'b11) makes `prog_req_o` pulse for one cycle after chip-select falls. It carries `prog_op_o` (0 erase, 1 write, 2 erase-all, 3 write-all), the address and the data. Erase operations carry data 0.
- R8: Opcode 2'b00 with top address bits 2'b10 requests erase-all, and with 2'b01 requests write-all with a data word. Both report address 0.
- R9: An instruction cut short by chip-select falling before its last bit issues no request.
- R10: After the last bit of an instruction, further clocks and data-in are ignored until chip-select falls.
- R11: When chip-select rises after a program request and before a new start bit, the output is enabled and shows the inverse of `prog_busy_i`.
- R12: When chip-select is low, the output-enable is 0 from the next cycle after the synchronized low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial chip-select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| org_word_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| prog_busy_i | input | 1 | Sequencer busy flag |
| rd_data_i | input | 16 | Read port data, valid the cycle after `rd_en_o` |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for `do_o` (0 = high impedance) |
| rd_en_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 7 | Read address (byte or word units) |
| prog_req_o | output | 1 | One-cycle program request |
| prog_op_o | output | 2 | Program operation code |
| prog_addr_o | output | 7 | Program address |
| prog_data_o | output | 16 | Program data |

## Verification
On every cycle, the embedded properties check the following. A program request pulses for only one cycle, only after chip-select went low, and only with programming enabled. Read requests are single-cycle and occur only during an active read stream. The output-enable drops once chip-select is low. The scenarios are needed for the bit ordering of the read stream, the dummy zero, and address wrap in both organizations. They also cover the ignored pre-start clocks and trailing bits, the decoding of the extended opcodes into the right request fields, and the ready/busy value seen on a later chip-select.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [1:0] {
      PG_ERASE = 2'd0,
      PG_WRITE = 2'd1,
      PG_ERAL  = 2'd2,
      PG_WRAL  = 2'd3
   } prog_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_READ,
      ST_DONE
   } fe_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int AW_MAX = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_rise,
   input  logic              di_s,
   input  logic              org_word,
   output logic              rd_start,
   output logic [AW_MAX-1:0] rd_start_addr,
   output logic              prog_req,
   output prog_op_e          prog_op,
   output logic [AW_MAX-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              stat_arm,
   output logic              cmd_idle
);
   localparam int DW_BYTE = DATA_W / 2;
   localparam int SR_W    = 2 + AW_MAX + DATA_W;
   localparam int CW      = $clog2(SR_W + 2);

   fe_state_e         st;
   logic [SR_W-1:0]   sr, nsr;
   logic [CW-1:0]     cnt, cnt_nx, hdr_len, dat_len;
   logic              cs_prev, wen_q, pend_q;
   prog_op_e          op_q;
   logic [AW_MAX-1:0] addr_q, hdr_addr;
   logic [DATA_W-1:0] data_q, hdr_data;
   logic [1:0]        opc, ext;

   always_comb begin
      nsr     = {sr[SR_W-2:0], di_s};
      cnt_nx  = cnt + CW'(1);
      hdr_len = org_word ? CW'(2 + ADDR_W) : CW'(2 + AW_MAX);
      dat_len = org_word ? CW'(DATA_W) : CW'(DW_BYTE);
      if (org_word) begin
         opc      = nsr[ADDR_W+1:ADDR_W];
         ext      = nsr[ADDR_W-1:ADDR_W-2];
         hdr_addr = {1'b0, nsr[ADDR_W-1:0]};
         hdr_data = nsr[DATA_W-1:0];
      end else begin
         opc      = nsr[AW_MAX+1:AW_MAX];
         ext      = nsr[AW_MAX-1:AW_MAX-2];
         hdr_addr = nsr[AW_MAX-1:0];
         hdr_data = {{DW_BYTE{1'b0}}, nsr[DW_BYTE-1:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sr       <= '0;
         cnt      <= '0;
         cs_prev  <= 1'b0;
         wen_q    <= 1'b0;
         pend_q   <= 1'b0;
         op_q     <= PG_ERASE;
         addr_q   <= '0;
         data_q   <= '0;
         rd_start <= 1'b0;
         prog_req <= 1'b0;
         stat_arm <= 1'b0;
      end else begin
         rd_start <= 1'b0;
         prog_req <= 1'b0;
         cs_prev  <= cs_s;
         if (!cs_s) begin
            st  <= ST_IDLE;
            cnt <= '0;
            if (cs_prev) begin
               prog_req <= pend_q;
               pend_q   <= 1'b0;
               if (pend_q) stat_arm <= 1'b1;
            end
         end else if (sclk_rise) begin
            case (st)
               ST_IDLE: if (di_s) begin
                  st       <= ST_CMD;
                  cnt      <= '0;
                  sr       <= '0;
                  stat_arm <= 1'b0;
               end
               ST_CMD: begin
                  sr  <= nsr;
                  cnt <= cnt_nx;
                  if (cnt_nx == hdr_len) begin
                     cnt    <= '0;
                     data_q <= '0;
                     addr_q <= (opc == 2'b00) ? '0 : hdr_addr;
                     st     <= ST_DONE;
                     case (opc)
                        2'b10: begin
                           rd_start <= 1'b1;
                           st       <= ST_READ;
                        end
                        2'b11: begin
                           op_q   <= PG_ERASE;
                           pend_q <= wen_q;
                        end
                        2'b01: begin
                           op_q <= PG_WRITE;
                           st   <= ST_DATA;
                        end
                        default: begin
                           case (ext)
                              2'b11: wen_q <= 1'b1;
                              2'b00: wen_q <= 1'b0;
                              2'b10: begin
                                 op_q   <= PG_ERAL;
                                 pend_q <= wen_q;
                              end
                              default: begin
                                 op_q <= PG_WRAL;
                                 st   <= ST_DATA;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  sr  <= nsr;
                  cnt <= cnt_nx;
                  if (cnt_nx == dat_len) begin
                     data_q <= hdr_data;
                     pend_q <= wen_q;
                     st     <= ST_DONE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_start_addr = addr_q;
   assign prog_op       = op_q;
   assign prog_addr     = addr_q;
   assign prog_data     = data_q;
   assign cmd_idle      = (st == ST_IDLE);

   p_req_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(!cs_s));
   p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);
   p_req_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(wen_q));
endmodule

// File: rtl/mw_rd_stream.sv
module mw_rd_stream #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int AW_MAX = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_rise,
   input  logic              org_word,
   input  logic              start,
   input  logic [AW_MAX-1:0] start_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_en,
   output logic [AW_MAX-1:0] rd_addr,
   output logic              bit_o,
   output logic              active
);
   localparam int DW_BYTE = DATA_W / 2;
   localparam int CW      = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] out_sr, aligned;
   logic [CW-1:0]     cnt, last_idx;
   logic [AW_MAX-1:0] mask;
   logic              ld;

   always_comb begin
      last_idx = org_word ? CW'(DATA_W - 1) : CW'(DW_BYTE - 1);
      mask     = org_word ? {1'b0, {ADDR_W{1'b1}}} : {AW_MAX{1'b1}};
      aligned  = org_word ? rd_data : {rd_data[DW_BYTE-1:0], {DW_BYTE{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr  <= '0;
         cnt     <= '0;
         rd_en   <= 1'b0;
         rd_addr <= '0;
         bit_o   <= 1'b0;
         active  <= 1'b0;
         ld      <= 1'b0;
      end else begin
         rd_en <= 1'b0;
         ld    <= rd_en;
         if (ld) out_sr <= aligned;
         if (!cs_s) begin
            active <= 1'b0;
            rd_en  <= 1'b0;
            ld     <= 1'b0;
         end else if (start) begin
            active  <= 1'b1;
            bit_o   <= 1'b0;
            rd_en   <= 1'b1;
            rd_addr <= start_addr & mask;
            cnt     <= '0;
         end else if (sclk_rise && active) begin
            bit_o  <= out_sr[DATA_W-1];
            out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            if (cnt == last_idx) begin
               cnt     <= '0;
               rd_addr <= (rd_addr + AW_MAX'(1)) & mask;
               rd_en   <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   p_rden_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
   p_rden_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> active);
endmodule

// File: rtl/mw_dout.sv
module mw_dout (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic rd_active,
   input  logic rd_bit,
   input  logic stat_arm,
   input  logic cmd_idle,
   input  logic prog_busy,
   output logic do_o,
   output logic do_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         do_o  <= 1'b0;
         do_oe <= 1'b0;
      end else begin
         do_oe <= cs_s & (rd_active | (stat_arm & cmd_idle));
         do_o  <= rd_active ? rd_bit : ~prog_busy;
      end
   end

   p_oe_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !do_oe);
endmodule

// File: rtl/mw_front.sv
module mw_front
   import mw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int AW_MAX = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sclk_i,
   input  logic              di_i,
   input  logic              org_word_i,
   input  logic              prog_busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              do_o,
   output logic              do_oe_o,
   output logic              rd_en_o,
   output logic [AW_MAX-1:0] rd_addr_o,
   output logic              prog_req_o,
   output logic [1:0]        prog_op_o,
   output logic [AW_MAX-1:0] prog_addr_o,
   output logic [DATA_W-1:0] prog_data_o
);
   generate
      if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_dw
         $error("DATA_W must be even and at least 4");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic              cs_s, sclk_s, di_s, sclk_d, sclk_rise;
   logic              rd_start, stat_arm, cmd_idle, rd_active, rd_bit;
   logic [AW_MAX-1:0] rd_start_addr;
   prog_op_e          op;

   mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sclk_i, di_i}),
      .q_o   (sync_q)
   );
   assign {cs_s, sclk_s, di_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   assign sclk_rise = sclk_s & ~sclk_d;

   mw_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_s          (cs_s),
      .sclk_rise     (sclk_rise),
      .di_s          (di_s),
      .org_word      (org_word_i),
      .rd_start      (rd_start),
      .rd_start_addr (rd_start_addr),
      .prog_req      (prog_req_o),
      .prog_op       (op),
      .prog_addr     (prog_addr_o),
      .prog_data     (prog_data_o),
      .stat_arm      (stat_arm),
      .cmd_idle      (cmd_idle)
   );
   assign prog_op_o = op;

   mw_rd_stream #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .sclk_rise  (sclk_rise),
      .org_word   (org_word_i),
      .start      (rd_start),
      .start_addr (rd_start_addr),
      .rd_data    (rd_data_i),
      .rd_en      (rd_en_o),
      .rd_addr    (rd_addr_o),
      .bit_o      (rd_bit),
      .active     (rd_active)
   );

   mw_dout u_dout (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .rd_active (rd_active),
      .rd_bit    (rd_bit),
      .stat_arm  (stat_arm),
      .cmd_idle  (cmd_idle),
      .prog_busy (prog_busy_i),
      .do_o      (do_o),
      .do_oe     (do_oe_o)
   );
endmodule

// File: tb/mw_front_bench.sv
module mw_front_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cs_i = 1'b0, sclk_i = 1'b0, di_i = 1'b0, org_word_i = 1'b1;
   logic        prog_busy_i;
   logic [15:0] rd_data_i = '0;
   logic        do_o, do_oe_o, rd_en_o, prog_req_o;
   logic [6:0]  rd_addr_o, prog_addr_o;
   logic [1:0]  prog_op_o;
   logic [15:0] prog_data_o;

   int n_tests = 0, n_fail = 0, n_req = 0, busy_cnt = 0;
   logic smp_do, smp_oe;
   logic [24:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mw_front u_mw_front (.*);

   function automatic logic [15:0] pat(input logic [6:0] a);
      return {{1'b0, a} ^ 8'h3C, {1'b0, a} ^ 8'h96};
   endfunction

   // read port and busy model
   always @(posedge clk) begin
      if (rd_en_o) rd_data_i <= pat(rd_addr_o);
      if (prog_req_o) busy_cnt <= 60;
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
   end
   assign prog_busy_i = (busy_cnt != 0);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) if (rst_n && prog_req_o) begin
      n_req++;
      n_tests++;
      if (exp_q.size() == 0) begin
         n_fail++;
         $display("FAIL R6/R9 unexpected request actual=%0h expected=none",
                  {prog_op_o, prog_addr_o, prog_data_o});
      end else begin
         logic [24:0] e;
         e = exp_q.pop_front();
         if ({prog_op_o, prog_addr_o, prog_data_o} !== e) begin
            n_fail++;
            $display("FAIL R7 request actual=%0h expected=%0h",
                     {prog_op_o, prog_addr_o, prog_data_o}, e);
         end
      end
   end

   task automatic clk_bit(input logic b);
      di_i = b;
      repeat (4) @(negedge clk);
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      smp_do = do_o;
      smp_oe = do_oe_o;
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
   endtask

   task automatic cs_up();
      cs_i = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_down();
      cs_i = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   function automatic int aw();
      return org_word_i ? 6 : 7;
   endfunction

   task automatic hdr(input logic [1:0] op, input logic [6:0] a);
      send(1, 1);
      send(op, 2);
      send(a, aw());
   endtask

   task automatic read_word(input string req, input logic [15:0] w, input int nb);
      for (int i = nb - 1; i >= 0; i--) begin
         clk_bit(1'b0);
         check(req, {smp_oe, smp_do}, {1'b1, w[i]});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int r0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 reset oe", do_oe_o, 0);
      check("R1 reset rd_en", rd_en_o, 0);
      check("R1 reset req", prog_req_o, 0);

      // R2: clocks with DI low before start bit
      cs_up();
      send(0, 5);
      check("R2 no output before start", smp_oe, 0);
      // R3 word read with dummy zero
      hdr(2'b10, 7'd5);
      check("R3 dummy zero", {smp_oe, smp_do}, 2'b10);
      read_word("R3 word read", pat(7'd5), 16);
      read_word("R5 sequential next", pat(7'd6), 16);
      cs_down();
      check("R12 oe low after cs", do_oe_o, 0);

      // R5 wrap in word organization
      cs_up();
      hdr(2'b10, 7'd63);
      read_word("R5 last word", pat(7'd63), 16);
      read_word("R5 wrap to zero", pat(7'd0), 16);
      cs_down();

      // R6 write while disabled
      r0 = n_req;
      cs_up(); hdr(2'b01, 7'd3); send(16'h1111, 16); cs_down();
      repeat (20) @(negedge clk);
      check("R6 disabled write", n_req - r0, 0);

      // enable
      cs_up(); hdr(2'b00, 7'h30); cs_down();
      // R7 write
      exp_q.push_back({2'd1, 7'd10, 16'hBEEF});
      cs_up(); hdr(2'b01, 7'd10); send(16'hBEEF, 16); cs_down();
      check("R7 write consumed", exp_q.size(), 0);
      // R11 status
      cs_up();
      check("R11 busy", {do_oe_o, do_o}, 2'b10);
      repeat (80) @(negedge clk);
      check("R11 ready", {do_oe_o, do_o}, 2'b11);
      cs_down();

      // R8 erase, erase-all, write-all; R7 erase fields
      exp_q.push_back({2'd0, 7'd7, 16'h0});
      cs_up(); hdr(2'b11, 7'd7); cs_down();
      exp_q.push_back({2'd2, 7'd0, 16'h0});
      cs_up(); hdr(2'b00, 7'h20); cs_down();
      exp_q.push_back({2'd3, 7'd0, 16'h1234});
      cs_up(); hdr(2'b00, 7'h10); send(16'h1234, 16); cs_down();
      check("R8 extended ops consumed", exp_q.size(), 0);

      // R10 trailing clocks ignored
      exp_q.push_back({2'd1, 7'd20, 16'h0F0F});
      cs_up(); hdr(2'b01, 7'd20); send(16'h0F0F, 16);
      send(5'h1F, 5);
      check("R10 no output on trailing clocks", smp_oe, 0);
      cs_down();
      check("R10 single request", exp_q.size(), 0);

      // R9 incomplete instruction
      r0 = n_req;
      cs_up(); hdr(2'b01, 7'd21); send(10'h3FF, 10); cs_down();
      repeat (20) @(negedge clk);
      check("R9 truncated write", n_req - r0, 0);

      // R4 byte organization
      org_word_i = 1'b0;
      cs_up();
      hdr(2'b10, 7'h45);
      check("R4 byte dummy", {smp_oe, smp_do}, 2'b10);
      read_word("R4 byte read", {8'h00, pat(7'h45)[7:0]}, 8);
      read_word("R5 byte sequential", {8'h00, pat(7'h46)[7:0]}, 8);
      cs_down();
      cs_up(); hdr(2'b10, 7'h7F);
      read_word("R4 byte top", {8'h00, pat(7'h7F)[7:0]}, 8);
      read_word("R5 byte wrap", {8'h00, pat(7'h00)[7:0]}, 8);
      cs_down();
      exp_q.push_back({2'd1, 7'h7F, 16'h00A5});
      cs_up(); hdr(2'b01, 7'h7F); send(8'hA5, 8); cs_down();
      check("R4 byte write consumed", exp_q.size(), 0);

      // R6 disable then write
      r0 = n_req;
      cs_up(); hdr(2'b00, 7'h00); cs_down();
      cs_up(); hdr(2'b01, 7'h11); send(8'h5A, 8); cs_down();
      repeat (20) @(negedge clk);
      check("R6 write after disable", n_req - r0, 0);
      check("R12 final oe", do_oe_o, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule